// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block derives periodic events from a 32768 Hz time base. The base arrives as a one-cycle enable, `tick_en`, in the system clock domain. Each tick advances a free-running 16-bit count.

A 4-bit rate code sets the event period as a power of two of the base. An event fires whenever the count reaches a multiple of that period. Because the boundaries come from the free-running count, rewriting the rate code realigns the divider with no extra step: the next event lands on the next multiple of the new period.

At each event the block can do two things:
- When the periodic-interrupt enable is set, it sets a sticky interrupt-request flag and a sticky periodic flag. Both stay set until cleared.
- When the square-wave enable is set, it emits a one-cycle pulse.

Top module: `periodic_irq_divider`

## Requirements
- R1: After reset `irq_flag`, `per_flag` and `sqw_pulse` are 0, and the free-running base count is 0.
- R2: A rate code of 0 produces no event: no pulse and no flag set, whatever the enables are.
- R3: For a rate code n from 3 to 15, events come every 2^(n-1) ticks (code 3 gives 4 ticks, code 15 gives 16384 ticks).
- R4: Rate code 1 gives a period of 128 ticks and rate code 2 gives 256 ticks.
- R5: With both `pie_en` and `sqw_en` low, no event has any visible effect.
- R6: The base count advances by one on each tick, wrapping at 2^16. An event fires on the tick that brings the count to a multiple of the period. After reset with code 4 and a tick every cycle, the first pulse follows the 8th tick.
- R7: At an event with `pie_en` high, `irq_flag` and `per_flag` both become 1 on the same edge. They stay at 1 until a cycle with `flag_clr` high. If an event and `flag_clr` fall in the same cycle, the flags are set.
- R8: At an event with `sqw_en` high, `sqw_pulse` is 1 for exactly one cycle.
- R9: With `pie_en` low, events never set the flags, even while square-wave pulses are produced.
- R10: With `tick_en` low, the count holds and no event fires.
- R11: A rate code change takes effect at the next boundary of the new period on the unchanged base count. Starting at count 8, switching from code 4 to code 5 puts the next event at count 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle strobe at the 32768 Hz base rate |
| rate_sel | input | 4 | Rate code; 0 disables events |
| pie_en | input | 1 | Periodic-interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| flag_clr | input | 1 | Clears both sticky flags |
| irq_flag | output | 1 | Sticky interrupt-request flag |
| per_flag | output | 1 | Sticky periodic flag |
| sqw_pulse | output | 1 | One-cycle pulse per event when enabled |

## Verification
The assertions check these properties on every cycle:
- The two flags always agree.
- A pulse never lasts more than one cycle.
- No pulse follows a zero rate code, a low square-wave enable or a missing tick.
- No flag rises without the periodic enable.
- A clear without a coinciding event drops the flags.

Other properties depend on history over many cycles: the exact event spacing for each code, the aliasing of codes 1 and 2, alignment to the base count, and the realignment after a rate change. Only the bench's reference model and its timed scenarios can show these.

// File: rtl/pid_pkg.sv
package pid_pkg;
    localparam int CNT_W  = 16;
    localparam int RATE_W = 4;

    typedef struct packed {
        logic irq;
        logic per;
        logic pulse;
    } flag_state_t;

    // Effective code: codes 1 and 2 alias to the 8/9 rates; log2(period) = eff - 1.
    function automatic logic [RATE_W:0] rate_to_shift(input logic [RATE_W-1:0] code);
        logic [RATE_W:0] eff;
        eff = (code <= 2) ? ({1'b0, code} + 5'd7) : {1'b0, code};
        return eff - 5'd1;
    endfunction
endpackage

// File: rtl/pid_rate_decoder.sv
module pid_rate_decoder
    import pid_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int RW = RATE_W
) (
    input  logic [RW-1:0] rate_sel,
    output logic          rate_nz,
    output logic [CW-1:0] period_mask
);
    localparam int SHW = RW + 1;

    logic [SHW-1:0] shift;

    always_comb begin
        shift       = rate_to_shift(rate_sel);
        rate_nz     = (rate_sel != '0);
        period_mask = '0;
        for (int b = 0; b < CW; b++) begin
            period_mask[b] = (b < int'(shift));
        end
    end
endmodule

// File: rtl/pid_base_counter.sv
module pid_base_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    output logic [CW-1:0] cnt_next
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = tick_en ? cnt_q + 1'b1 : cnt_q;
        cnt_next = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pid_event_gen.sv
module pid_event_gen #(
    parameter int CW = 16
) (
    input  logic          tick_en,
    input  logic [CW-1:0] cnt_next,
    input  logic [CW-1:0] period_mask,
    input  logic          rate_nz,
    input  logic          pie_en,
    input  logic          sqw_en,
    output logic          ev_pie,
    output logic          ev_sqw
);
    logic aligned, active, fire;

    always_comb begin
        aligned = ((cnt_next & period_mask) == '0);
        active  = rate_nz && (pie_en || sqw_en);
        fire    = tick_en && active && aligned;
        ev_pie  = fire && pie_en;
        ev_sqw  = fire && sqw_en;
    end
endmodule

// File: rtl/pid_flag_reg.sv
module pid_flag_reg
    import pid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_pie,
    input  logic ev_sqw,
    input  logic flag_clr,
    output logic irq_flag,
    output logic per_flag,
    output logic sqw_pulse
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = ev_sqw;
        if (ev_pie) begin
            st_d.irq = 1'b1;
            st_d.per = 1'b1;
        end else if (flag_clr) begin
            st_d.irq = 1'b0;
            st_d.per = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_flag  = st_q.irq;
    assign per_flag  = st_q.per;
    assign sqw_pulse = st_q.pulse;
endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider
    import pid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              pie_en,
    input  logic              sqw_en,
    input  logic              flag_clr,
    output logic              irq_flag,
    output logic              per_flag,
    output logic              sqw_pulse
);
    logic [CNT_W-1:0] cnt_next, period_mask;
    logic             rate_nz, ev_pie, ev_sqw;

    pid_rate_decoder #(.CW(CNT_W), .RW(RATE_W)) u_dec (
        .rate_sel(rate_sel), .rate_nz(rate_nz), .period_mask(period_mask)
    );

    pid_base_counter #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_next(cnt_next)
    );

    pid_event_gen #(.CW(CNT_W)) u_ev (
        .tick_en(tick_en), .cnt_next(cnt_next), .period_mask(period_mask),
        .rate_nz(rate_nz), .pie_en(pie_en), .sqw_en(sqw_en),
        .ev_pie(ev_pie), .ev_sqw(ev_sqw)
    );

    pid_flag_reg u_flg (
        .clk(clk), .rst_n(rst_n), .ev_pie(ev_pie), .ev_sqw(ev_sqw),
        .flag_clr(flag_clr), .irq_flag(irq_flag), .per_flag(per_flag),
        .sqw_pulse(sqw_pulse)
    );
endmodule

// File: rtl/pid_checker.sv
module pid_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic [3:0] rate_sel,
    input logic       pie_en,
    input logic       sqw_en,
    input logic       flag_clr,
    input logic       irq_flag,
    input logic       per_flag,
    input logic       sqw_pulse
);
    AST_FLAGS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag == per_flag);                                         // R7
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_pulse |=> !sqw_pulse);                                     // R8
    AST_ZERO_RATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 4'd0) |=> (!sqw_pulse && !$rose(per_flag)));      // R2
    AST_ENABLES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!pie_en && !sqw_en) |=> (!sqw_pulse && !$rose(irq_flag)));    // R5
    AST_NO_PIE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !pie_en |=> !$rose(irq_flag));                                 // R9
    AST_NO_TICK_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> (!sqw_pulse && !$rose(per_flag)));                // R10
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !tick_en) |=> !irq_flag);                         // R7
endmodule

bind periodic_irq_divider pid_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
    .pie_en(pie_en), .sqw_en(sqw_en), .flag_clr(flag_clr),
    .irq_flag(irq_flag), .per_flag(per_flag), .sqw_pulse(sqw_pulse)
);

// File: tb/periodic_irq_divider_test.sv
`timescale 1ns/1ps
module periodic_irq_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       pie_en = 1'b0, sqw_en = 1'b0, flag_clr = 1'b0;
    logic       irq_flag, per_flag, sqw_pulse;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference model state
    int  m_cnt = 0;
    bit  m_flag = 0, m_pulse = 0;

    periodic_irq_divider uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
        .pie_en(pie_en), .sqw_en(sqw_en), .flag_clr(flag_clr),
        .irq_flag(irq_flag), .per_flag(per_flag), .sqw_pulse(sqw_pulse)
    );

    always #2.5 clk = ~clk;

    function automatic int period_of(input int code);
        int eff;
        eff = (code <= 2) ? code + 7 : code;
        return 1 << (eff - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0; m_pulse = 0;
        end else begin
            bit ev;
            ev = 0;
            if (tick_en) begin
                m_cnt = (m_cnt + 1) % 65536;
                if (rate_sel != 0 && (pie_en || sqw_en) &&
                    (m_cnt % period_of(rate_sel)) == 0) ev = 1;
            end
            m_pulse = ev && sqw_en;
            if (ev && pie_en) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // Per-cycle comparison against the model (R6 R7 R8 R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 R11 sqw_pulse", sqw_pulse, m_pulse);
            check("R7 irq_flag", irq_flag, m_flag);
            check("R7 per_flag", per_flag, m_flag);
        end
    end

    // Run n cycles, tick every cycle when tk, return pulse count
    task automatic run(input int n, input bit tk, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = tk;
            if (sqw_pulse) pulses++;
        end
    endtask

    initial begin
        int p, k;
        repeat (3) @(negedge clk);
        check("R1 irq_flag", irq_flag, 0);
        check("R1 sqw_pulse", sqw_pulse, 0);
        rst_n = 1'b1;

        // R6 alignment from reset count 0, then R11 rate change
        rate_sel = 4'd4; sqw_en = 1'b1; tick_en = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!sqw_pulse && k < 100);
        check("R6 first pulse tick", k, 8);
        rate_sel = 4'd5;
        k = 0;
        do begin @(negedge clk); k++; end while (!sqw_pulse && k < 100);
        check("R11 ticks to new boundary", k, 8);

        rate_sel = 4'd3; run(64, 1, p); check("R3 code3 pulses in 64", p, 16);
        rate_sel = 4'd6; run(256, 1, p); check("R3 code6 pulses in 256", p, 8);
        rate_sel = 4'd1; run(512, 1, p); check("R4 code1 pulses in 512", p, 4);
        rate_sel = 4'd2; run(512, 1, p); check("R4 code2 pulses in 512", p, 2);
        rate_sel = 4'd15; run(16384, 1, p); check("R3 code15 pulses", p, 1);
        check("R9 no flag without pie", irq_flag, 0);

        rate_sel = 4'd0; pie_en = 1'b1; run(300, 1, p);
        check("R2 zero rate pulses", p, 0);
        check("R2 zero rate flag", irq_flag, 0);

        rate_sel = 4'd3; pie_en = 1'b0; sqw_en = 1'b0; run(100, 1, p);
        check("R5 enables off pulses", p, 0);
        check("R5 enables off flag", irq_flag, 0);

        sqw_en = 1'b1; run(100, 0, p);
        check("R10 no tick pulses", p, 0);

        pie_en = 1'b1; run(8, 1, p);
        check("R7 flag set by event", irq_flag, 1);
        tick_en = 1'b0; run(20, 0, p);
        check("R7 flag sticky", per_flag, 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R7 flag cleared", irq_flag, 0);
        // clear held while events keep arriving: set wins
        flag_clr = 1'b1; run(40, 1, p); flag_clr = 1'b0;
        run(30, 1, p);
        check("R8 pulses with tick every other config", p > 0, 1);

        @(negedge clk); done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule